// File: doc/BRIEF.md
# Dual-Bank Ratio Clock Divider with Sync

This block divides one fast clock into two output banks, `qa` and `qb`, whose frequencies stand in one of four fixed ratios, plus a slower feedback clock meant for an external phase detector. A single-cycle-resolution indicator, `syncOut`, warns ahead of the edge where both banks rise together. This gives a fixed reference point in system timing when the odd ratios are in use. Every output comes from a flip-flop clocked by the input clock, so the outputs carry no combinational glitches.

The 2-bit ratio select, the range select and the bypass input are captured while reset is held. Any later change has no effect until the next reset. Reset forces every output low and loads all counters to one common phase. As a result, the first advance after reset makes all three clocks rise together. In the low-frequency range, a divide-by-2 prescaler slows every divider. The bypass input overrides the range select, so that each input clock edge steps the dividers directly.

Top module: `clkRatioGen`

## Requirements
- R1: While `rst` is sampled high at a rising edge, `qa`, `qb`, `fbClk` and `syncOut` are all low after that edge.
- R2: With `freqSel` = 2'b00, the divisors are 4 for `qa`, 6 for `qb` and 24 for `fbClk`, and the coincidence period is 12 ticks.
- R3: With `freqSel` = 2'b01, the divisors are 2 for `qa`, 4 for `qb` and 16 for `fbClk`, and the coincidence period is 4 ticks.
- R4: With `freqSel` = 2'b10, the divisors are 4 for `qa`, 10 for `qb` and 40 for `fbClk`, and the coincidence period is 20 ticks.
- R5: With `freqSel` = 2'b11, the divisors are 2 for `qa`, 6 for `qb` and 24 for `fbClk`, and the coincidence period is 6 ticks.
- R6: The first tick after reset release drives `qa`, `qb` and `fbClk` high together. Every rise of `fbClk` coincides with a rise of both `qa` and `qb`.
- R7: Each divided output is high for the first half of its divisor in ticks and low for the second half.
- R8: Tick 0 is the common rise, and phase is the tick index modulo the coincidence period. `syncOut` is high for exactly one `qa` period. It starts half a `qa` period before the `qa` rise that falls four `qa` rises ahead of the next common rise. This gives start phases 6, 3, 2 and 3 for codes 00, 01, 10 and 11. Both edges of `syncOut` coincide with an edge of `qa`.
- R9: With `lowRange` = 1 and `bypass` = 0, a tick occurs on every second input edge, starting with the second edge after release, so every output runs at half rate.
- R10: With `bypass` = 1, every input edge after release is a tick, whatever the value of `lowRange`.
- R11: Changes on `freqSel`, `lowRange` or `bypass` while `rst` is low leave the output pattern unchanged.
- R12: Outputs change only on a tick. Between ticks they hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock (VCO rate) |
| rst | input | 1 | Synchronous reset, active high; captures configuration |
| freqSel | input | 2 | Bank ratio select |
| lowRange | input | 1 | 1 selects the divide-by-2 prescaler |
| bypass | input | 1 | 1 forces one tick per input edge |
| qa | output | 1 | Bank A clock |
| qb | output | 1 | Bank B clock |
| fbClk | output | 1 | Feedback clock for the phase detector |
| syncOut | output | 1 | Coincidence warning pulse |

## Verification
The assertions assume that `rst` is held for at least one rising edge before any output is judged. They also assume that the configuration which matters is the one present on the last edge of reset. The stimulus changes every input at falling edges only, and it holds reset for several edges on each mode change. The only configuration changes made outside reset are the deliberate ones that test R11. The properties are stated in terms of the tick strobe and the output edges, so they hold under any configuration.

// File: rtl/clkRatioPkg.sv
package clkRatioPkg;
  localparam int CNT_W    = 6;   // wide enough for the largest divisor (40)
  localparam int NUM_DIV  = 3;
  localparam int IDX_A    = 0;
  localparam int IDX_B    = 1;
  localparam int IDX_FB   = 2;
  localparam int SYNC_LEAD = 4;  // qa rises between sync centre and coincidence
  localparam int PRE_DIV  = 2;   // low-range prescale factor

  typedef logic [CNT_W-1:0] cnt_t;

  typedef struct packed {
    logic load;   // realign all counters to the common phase
    logic tick;   // advance all counters by one step
  } strobe_t;

  typedef struct packed {
    logic [1:0] sel;
    logic       lowRange;
    logic       bypass;
  } cfg_t;

  function automatic cnt_t divOf(input int idx, input logic [1:0] sel);
    int d;
    d = 4;
    if (idx == IDX_A) begin
      d = sel[0] ? 2 : 4;
    end else if (idx == IDX_B) begin
      case (sel)
        2'b00:   d = 6;
        2'b01:   d = 4;
        2'b10:   d = 10;
        default: d = 6;
      endcase
    end else begin
      case (sel)
        2'b00:   d = 24;
        2'b01:   d = 16;
        2'b10:   d = 40;
        default: d = 24;
      endcase
    end
    return cnt_t'(d);
  endfunction

  // Coincidence period = lcm of the two bank divisors
  function automatic cnt_t periodOf(input logic [1:0] sel);
    int p;
    case (sel)
      2'b00:   p = 12;
      2'b01:   p = 4;
      2'b10:   p = 20;
      default: p = 6;
    endcase
    return cnt_t'(p);
  endfunction

  // Phase where the sync window opens: half a qa period before the
  // qa rise that lies SYNC_LEAD qa periods ahead of the common rise.
  function automatic cnt_t syncStartOf(input logic [1:0] sel);
    int p;
    int a;
    int lead;
    p    = int'(periodOf(sel));
    a    = int'(divOf(IDX_A, sel));
    lead = (SYNC_LEAD * a) % p;
    return cnt_t'((2 * p - lead - a / 2) % p);
  endfunction
endpackage

// File: rtl/clkRatioDiv.sv
module clkRatioDiv #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         load,
  input  logic         tick,
  input  logic [W-1:0] divisor,
  output logic         clkOut
);
  logic [W-1:0] cnt;
  logic [W-1:0] cntNxt;
  logic [W-1:0] halfDiv;

  always_comb begin
    halfDiv = divisor >> 1;
    cntNxt  = (cnt == divisor - W'(1)) ? '0 : cnt + W'(1);
  end

  always_ff @(posedge clk) begin
    if (load) begin
      cnt    <= divisor - W'(1);   // next tick wraps to phase 0
      clkOut <= 1'b0;
    end else if (tick) begin
      cnt    <= cntNxt;
      clkOut <= (cntNxt < halfDiv);
    end
  end
endmodule

// File: rtl/clkRatioCtrl.sv
module clkRatioCtrl
  import clkRatioPkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  cfg_t    cfgIn,
  output cfg_t    cfgAct,
  output strobe_t strobes,
  output logic    syncOut
);
  localparam int PW = CNT_W + 1;

  cfg_t        cfgHeld;
  logic        preHalf;
  logic        useDiv2;
  cnt_t        phase;
  cnt_t        phaseNxt;
  cnt_t        period;
  cnt_t        syncStart;
  cnt_t        qaDiv;
  logic [PW-1:0] offset;
  logic        inWindow;

  // configuration is sampled only while reset is held
  always_ff @(posedge clk) begin
    if (rst) cfgHeld <= cfgIn;
  end
  assign cfgAct = rst ? cfgIn : cfgHeld;

  // prescaler: toggles every edge, tick on odd edges in low range
  always_ff @(posedge clk) begin
    if (rst) preHalf <= 1'b0;
    else     preHalf <= ~preHalf;
  end

  always_comb begin
    useDiv2      = cfgAct.lowRange & ~cfgAct.bypass;
    strobes.load = rst;
    strobes.tick = ~rst & (~useDiv2 | preHalf);
  end

  // coincidence phase sequencer and sync window
  always_comb begin
    period    = periodOf(cfgAct.sel);
    syncStart = syncStartOf(cfgAct.sel);
    qaDiv     = divOf(IDX_A, cfgAct.sel);
    phaseNxt  = (phase == period - cnt_t'(1)) ? '0 : phase + cnt_t'(1);
    offset    = PW'(phaseNxt) + PW'(period) - PW'(syncStart);
    if (offset >= PW'(period)) offset = offset - PW'(period);
    inWindow  = (offset < PW'(qaDiv));
  end

  always_ff @(posedge clk) begin
    if (strobes.load) begin
      phase   <= period - cnt_t'(1);
      syncOut <= 1'b0;
    end else if (strobes.tick) begin
      phase   <= phaseNxt;
      syncOut <= inWindow;
    end
  end
endmodule

// File: rtl/clkRatioPath.sv
module clkRatioPath
  import clkRatioPkg::*;
(
  input  logic               clk,
  input  strobe_t            strobes,
  input  logic [1:0]         sel,
  output logic [NUM_DIV-1:0] divOut
);
  for (genvar i = 0; i < NUM_DIV; i++) begin : g_div
    cnt_t divisor;
    assign divisor = divOf(i, sel);
    clkRatioDiv #(.W(CNT_W)) uDiv (
      .clk    (clk),
      .load   (strobes.load),
      .tick   (strobes.tick),
      .divisor(divisor),
      .clkOut (divOut[i])
    );
  end
endmodule

// File: rtl/clkRatioGen.sv
module clkRatioGen
  import clkRatioPkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] freqSel,
  input  logic       lowRange,
  input  logic       bypass,
  output logic       qa,
  output logic       qb,
  output logic       fbClk,
  output logic       syncOut
);
  cfg_t               cfgIn;
  cfg_t               cfgAct;
  strobe_t            ctlStrobes;
  logic [NUM_DIV-1:0] divOut;
  logic               advTick;

  assign cfgIn = '{sel: freqSel, lowRange: lowRange, bypass: bypass};

  clkRatioCtrl uCtrl (
    .clk    (clk),
    .rst    (rst),
    .cfgIn  (cfgIn),
    .cfgAct (cfgAct),
    .strobes(ctlStrobes),
    .syncOut(syncOut)
  );

  clkRatioPath uPath (
    .clk    (clk),
    .strobes(ctlStrobes),
    .sel    (cfgAct.sel),
    .divOut (divOut)
  );

  assign qa      = divOut[IDX_A];
  assign qb      = divOut[IDX_B];
  assign fbClk   = divOut[IDX_FB];
  assign advTick = ctlStrobes.tick;
endmodule

// File: rtl/clkRatioGenChk.sv
module clkRatioGenChk (
  input logic clk,
  input logic rst,
  input logic qa,
  input logic qb,
  input logic fbClk,
  input logic syncOut,
  input logic advTick
);
  AST_RESET_FORCES_LOW: assert property (@(posedge clk)
    rst |=> (!qa && !qb && !fbClk && !syncOut)); // R1

  AST_FB_ON_COMMON_RISE: assert property (@(posedge clk) disable iff (rst)
    $rose(fbClk) |-> ($rose(qa) && $rose(qb))); // R6

  AST_SYNC_ON_QA_EDGE: assert property (@(posedge clk) disable iff (rst)
    ($rose(syncOut) || $fell(syncOut)) |-> (qa != $past(qa))); // R8

  AST_HOLD_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (rst)
    !$past(advTick) |-> ($stable(qa) && $stable(qb) && $stable(fbClk) && $stable(syncOut))); // R12
endmodule

bind clkRatioGen clkRatioGenChk uChk (
  .clk    (clk),
  .rst    (rst),
  .qa     (qa),
  .qb     (qb),
  .fbClk  (fbClk),
  .syncOut(syncOut),
  .advTick(advTick)
);

// File: tb/clkRatioGen_test.sv
`timescale 1ns/1ps
module clkRatioGen_test;
  localparam int HALF_NS = 10;  // 50 MHz

  typedef struct packed {
    int sel; int low; int byp; int flip;
    int da; int db; int dfb; int per; int sst;
  } vec_t;

  localparam int NROWS = 8;
  localparam vec_t TBL [NROWS] = '{
    '{0, 0, 0, 0, 4,  6, 24, 12, 6},   // R2
    '{1, 0, 0, 0, 2,  4, 16,  4, 3},   // R3
    '{2, 0, 0, 0, 4, 10, 40, 20, 2},   // R4
    '{3, 0, 0, 0, 2,  6, 24,  6, 3},   // R5
    '{0, 1, 0, 0, 4,  6, 24, 12, 6},   // R9 low range
    '{2, 1, 0, 1, 4, 10, 40, 20, 2},   // R9 + R11 config flipped after release
    '{3, 1, 1, 0, 2,  6, 24,  6, 3},   // R10 bypass beats low range
    '{1, 0, 0, 1, 2,  4, 16,  4, 3}    // R11 config flipped after release
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] freqSel = 2'b00;
  logic lowRange = 1'b0;
  logic bypass = 1'b0;
  logic qa, qb, fbClk, syncOut;
  int nChecks = 0;
  int nFails = 0;

  always #(HALF_NS) clk = ~clk;

  clkRatioGen uut (
    .clk(clk), .rst(rst), .freqSel(freqSel), .lowRange(lowRange),
    .bypass(bypass), .qa(qa), .qb(qb), .fbClk(fbClk), .syncOut(syncOut)
  );

  function automatic string rowTag(input vec_t v);
    if (v.flip != 0) return "R11";
    if (v.byp != 0)  return "R10";
    if (v.low != 0)  return "R9";
    case (v.sel)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic check(input string tag, input string what, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic runRow(input vec_t v);
    int p;
    int len;
    p   = (v.low != 0 && v.byp == 0) ? 2 : 1;
    len = 2 * v.dfb * p + 3;
    @(negedge clk);
    rst      = 1'b1;
    freqSel  = 2'(v.sel);
    lowRange = (v.low != 0);
    bypass   = (v.byp != 0);
    // R1: outputs forced low while reset is held, whatever came before
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R1", "qa", qa, 1'b0);
      check("R1", "qb", qb, 1'b0);
      check("R1", "fbClk", fbClk, 1'b0);
      check("R1", "syncOut", syncOut, 1'b0);
    end
    rst = 1'b0;
    if (v.flip != 0) begin   // R11: ignored until next reset
      freqSel  = ~freqSel;
      lowRange = ~lowRange;
      bypass   = ~bypass;
    end
    for (int c = 0; c < len; c++) begin
      int n;
      int t;
      logic eA, eB, eF, eS;
      @(negedge clk);
      n = (c + 1) / p;          // ticks completed (R9, R10)
      if (n == 0) begin
        eA = 1'b0; eB = 1'b0; eF = 1'b0; eS = 1'b0;
      end else begin
        t  = n - 1;             // R6: tick 0 is the common rise
        eA = (t % v.da)  < v.da / 2;   // R7 half-high duty
        eB = (t % v.db)  < v.db / 2;
        eF = (t % v.dfb) < v.dfb / 2;
        eS = (((t % v.per) + v.per - v.sst) % v.per) < v.da;
      end
      check(rowTag(v), "qa", qa, eA);
      check(rowTag(v), "qb", qb, eB);
      check(rowTag(v), "fbClk", fbClk, eF);
      check("R8", "syncOut", syncOut, eS);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin : main
    repeat (2) @(negedge clk);
    for (int r = 0; r < NROWS; r++) runRow(TBL[r]);
    // directed: reset asserted mid-stream in a fresh mode, then back to code 00
    runRow(TBL[3]);
    runRow(TBL[0]);
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule